// File: doc/BRIEF.md
# Framed PRBS Test Pattern Generator

This block is a serial test-pattern source for a T1/E1 transmit path. While it is running, it replaces the outgoing payload bits with a maximal-length pseudo-random sequence. Software picks one of four sequence lengths and can switch on a zero-run limiter that forces a one into the output before a long run of zeros forms. The 2^20-1 sequence with the limiter on gives the quasi-random signal pattern.

An external frame counter supplies a bit-period enable and markers for three positions: the T1 frame bit, E1 timeslot 0 and E1 timeslot 16. In framed mode the generator leaves those positions alone, so the original data passes through. It also halts during them, so the sequence picks up on the next payload bit. In unframed mode every bit is overwritten.

A controller with three named states gates the overwrite. IDLE passes data through and is left when start is sampled high (transition IDLE->ARM). ARM reseeds every sequence register to all ones, clears the zero-run counter and moves to RUN (ARM->RUN) while start stays high. RUN overwrites payload bits. Dropping start in ARM or RUN returns the controller to IDLE (ARM->IDLE, RUN->IDLE).

Top module: `prbs_pattern_gen`

## Requirements
- R1: pat_sel chooses the sequence. The four codes are 0: x^11+x^9+1, 1: x^15+x^14+1, 2: x^20+x^3+1 and 3: x^23+x^18+1. For degree n and tap k, register s shifts towards its top bit, the output bit is s[n-1], and s[n-1]^s[k-1] enters s[0]. The register is seeded to all ones.
- R2: With zero_lim high and pat_sel 0 or 1, data_out never shows eight or more consecutive zeros across overwritten bits. A one is forced when seven zeros have already gone out and the raw bit is zero.
- R3: With zero_lim high and pat_sel 2 or 3, the overwritten output never shows fifteen or more consecutive zeros. A one is forced after fourteen zeros.
- R4: A forced one changes only the output bit and clears the zero-run count. The sequence register continues exactly as if no bit had been forced.
- R5: With framed high and e1_mode low, a bit with frame_bit_mark high is not overwritten. ovr_valid is 0 and data_out equals data_in.
- R6: With framed and e1_mode high, ts0_mark bits are never overwritten. ts16_mark bits are protected only when cas_frame is high; otherwise they are overwritten.
- R7: During a protected bit the sequence does not advance, so the next payload bit carries the next sequence bit.
- R8: With framed low, every enabled bit is overwritten whatever the markers show.
- R9: start sampled high moves IDLE->ARM->RUN, and overwriting begins in the cycle after ARM. start sampled low makes ovr_valid 0 from the next cycle on. A restart reseeds the sequence.
- R10: A cycle with bit_en low does not overwrite and does not advance the sequence.
- R11: After reset, ovr_valid is 0 and data_out follows data_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One bit period in this cycle |
| data_in | input | 1 | Original transmit bit |
| frame_bit_mark | input | 1 | Current bit is the T1 frame bit |
| ts0_mark | input | 1 | Current bit lies in E1 timeslot 0 |
| ts16_mark | input | 1 | Current bit lies in E1 timeslot 16 |
| pat_sel | input | 2 | Sequence select (see R1) |
| zero_lim | input | 1 | Zero-run limiter enable |
| framed | input | 1 | Protect framing and signalling positions |
| e1_mode | input | 1 | 1 selects E1 position rules, 0 selects T1 |
| cas_frame | input | 1 | E1 signalling framing in use (protects timeslot 16) |
| start | input | 1 | Run the pattern overwrite |
| data_out | output | 1 | Transmit bit after overwrite |
| ovr_valid | output | 1 | The current bit carries a pattern bit |

## Verification
Each of the four sequences runs unframed against an independent shift-register model with scattered marker pulses. A wrong polynomial, a wrong seed or wrong marker handling in unframed mode all show up as a bit mismatch. The limiter runs on the 2^11-1 sequence for more than a full period, where natural runs of up to ten zeros must be cut at seven, and on the 2^23-1 sequence at its longer limit. Comparing the output afterwards exposes a forced one that disturbed the register. The T1 193-bit frame and the E1 frames, with and without signalling framing, separate pausing from skipping at protected bits. Bit-enable gaps and a stop/restart check the hold, the reseed and the start latency.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;

    localparam int NUM_PAT  = 4;
    localparam int SEL_W    = $clog2(NUM_PAT);
    localparam int ZRUN_W   = 4;
    localparam int CAP_SHORT = 7;
    localparam int CAP_LONG  = 14;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_t;

    function automatic int pat_deg(input int idx);
        case (idx)
            0:       return 11;
            1:       return 15;
            2:       return 20;
            default: return 23;
        endcase
    endfunction

    function automatic int pat_tap(input int idx);
        case (idx)
            0:       return 9;
            1:       return 14;
            2:       return 3;
            default: return 18;
        endcase
    endfunction

    function automatic logic [ZRUN_W-1:0] zero_cap(input logic [SEL_W-1:0] sel);
        return (sel >= SEL_W'(2)) ? ZRUN_W'(CAP_LONG) : ZRUN_W'(CAP_SHORT);
    endfunction

endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
    parameter int DEG = 11,
    parameter int TAP = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed,
    input  logic step,
    output logic out_bit
);

    logic [DEG-1:0] sreg;
    logic           fb;

    assign fb      = sreg[DEG-1] ^ sreg[TAP-1];
    assign out_bit = sreg[DEG-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '1;
        end else if (seed) begin
            sreg <= '1;
        end else if (step) begin
            sreg <= {sreg[DEG-2:0], fb};
        end
    end

endmodule

// File: rtl/prbs_zero_limiter.sv
module prbs_zero_limiter
    import prbs_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    input  logic             raw_bit,
    output logic             out_bit
);

    logic [ZRUN_W-1:0] zrun;
    logic              force_one;

    assign force_one = enable && !raw_bit && (zrun >= zero_cap(sel));
    assign out_bit   = raw_bit | force_one;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zrun <= '0;
        end else if (clr) begin
            zrun <= '0;
        end else if (step) begin
            if (out_bit) begin
                zrun <= '0;
            end else if (zrun != '1) begin
                zrun <= zrun + ZRUN_W'(1);
            end
        end
    end

endmodule

// File: rtl/prbs_slot_guard.sv
module prbs_slot_guard (
    input  logic framed,
    input  logic e1_mode,
    input  logic cas_frame,
    input  logic frame_bit_mark,
    input  logic ts0_mark,
    input  logic ts16_mark,
    output logic protect
);

    logic e1_hit;
    logic t1_hit;

    assign e1_hit  = ts0_mark || (cas_frame && ts16_mark);
    assign t1_hit  = frame_bit_mark;
    assign protect = framed && (e1_mode ? e1_hit : t1_hit);

endmodule

// File: rtl/prbs_gen_ctrl.sv
module prbs_gen_ctrl
    import prbs_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic seed,
    output logic running
);

    gen_state_t state;
    gen_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = ST_IDLE;
        unique case (state)
            ST_IDLE: nxt = start ? ST_ARM : ST_IDLE;
            ST_ARM:  nxt = start ? ST_RUN : ST_IDLE;
            ST_RUN:  nxt = start ? ST_RUN : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        seed    = 1'b0;
        running = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ARM:  seed    = 1'b1;
            ST_RUN:  running = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
    import prbs_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             data_in,
    input  logic             frame_bit_mark,
    input  logic             ts0_mark,
    input  logic             ts16_mark,
    input  logic [SEL_W-1:0] pat_sel,
    input  logic             zero_lim,
    input  logic             framed,
    input  logic             e1_mode,
    input  logic             cas_frame,
    input  logic             start,
    output logic             data_out,
    output logic             ovr_valid
);

    logic               seed;
    logic               running;
    logic               protect;
    logic               adv;
    logic [NUM_PAT-1:0] lfsr_bits;
    logic               raw_bit;
    logic               lim_bit;

    prbs_gen_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .seed    (seed),
        .running (running)
    );

    prbs_slot_guard u_guard (
        .framed         (framed),
        .e1_mode        (e1_mode),
        .cas_frame      (cas_frame),
        .frame_bit_mark (frame_bit_mark),
        .ts0_mark       (ts0_mark),
        .ts16_mark      (ts16_mark),
        .protect        (protect)
    );

    assign adv = running && bit_en && !protect;

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_seq
        logic step_g;
        assign step_g = adv && (int'(pat_sel) == g);
        prbs_lfsr #(
            .DEG (pat_deg(g)),
            .TAP (pat_tap(g))
        ) u_lfsr (
            .clk     (clk),
            .rst_n   (rst_n),
            .seed    (seed),
            .step    (step_g),
            .out_bit (lfsr_bits[g])
        );
    end

    assign raw_bit = lfsr_bits[pat_sel];

    prbs_zero_limiter u_zlim (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (seed),
        .step    (adv),
        .enable  (zero_lim),
        .sel     (pat_sel),
        .raw_bit (raw_bit),
        .out_bit (lim_bit)
    );

    assign ovr_valid = adv;
    assign data_out  = adv ? lim_bit : data_in;

endmodule

// File: rtl/prbs_pattern_gen_chk.sv
module prbs_pattern_gen_chk
    import prbs_gen_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             data_in,
    input logic             frame_bit_mark,
    input logic             ts0_mark,
    input logic             ts16_mark,
    input logic [SEL_W-1:0] pat_sel,
    input logic             zero_lim,
    input logic             framed,
    input logic             e1_mode,
    input logic             cas_frame,
    input logic             start,
    input logic             data_out,
    input logic             ovr_valid
);

    logic [4:0] zc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zc <= '0;
        end else if (!start || !zero_lim) begin
            zc <= '0;
        end else if (ovr_valid) begin
            if (data_out) zc <= '0;
            else if (zc != '1) zc <= zc + 5'd1;
        end
    end

    AST_ZRUN_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && zero_lim && pat_sel < 2'd2) |-> (zc <= 5'd7)); // R2

    AST_ZRUN_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (start && zero_lim && pat_sel >= 2'd2) |-> (zc <= 5'd14)); // R3

    AST_T1_FBIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (framed && !e1_mode && frame_bit_mark) |-> !ovr_valid); // R5

    AST_E1_TS0_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (framed && e1_mode && ts0_mark) |-> !ovr_valid); // R6

    AST_E1_TS16_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (framed && e1_mode && cas_frame && ts16_mark) |-> !ovr_valid); // R6

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_valid |-> (data_out == data_in)); // R11

    AST_STOP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !ovr_valid); // R9

    AST_NO_EN_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |-> !ovr_valid); // R10

endmodule

bind prbs_pattern_gen prbs_pattern_gen_chk u_chk (.*);

// File: tb/prbs_pattern_gen_tb.sv
`timescale 1ns/1ps
module prbs_pattern_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       data_in = 1'b0;
    logic       frame_bit_mark = 1'b0;
    logic       ts0_mark = 1'b0;
    logic       ts16_mark = 1'b0;
    logic [1:0] pat_sel = 2'd0;
    logic       zero_lim = 1'b0;
    logic       framed = 1'b0;
    logic       e1_mode = 1'b0;
    logic       cas_frame = 1'b0;
    logic       start = 1'b0;
    logic       data_out;
    logic       ovr_valid;

    int checks = 0;
    int errors = 0;

    logic [22:0] m_s;
    int          m_z;
    int          max_run;
    int          cur_run;

    always #2.5 clk = ~clk;

    prbs_pattern_gen u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .data_in(data_in),
        .frame_bit_mark(frame_bit_mark), .ts0_mark(ts0_mark), .ts16_mark(ts16_mark),
        .pat_sel(pat_sel), .zero_lim(zero_lim), .framed(framed), .e1_mode(e1_mode),
        .cas_frame(cas_frame), .start(start), .data_out(data_out), .ovr_valid(ovr_valid)
    );

    function automatic int deg_of(input logic [1:0] s);
        case (s) 2'd0: return 11; 2'd1: return 15; 2'd2: return 20; default: return 23; endcase
    endfunction
    function automatic int tap_of(input logic [1:0] s);
        case (s) 2'd0: return 9; 2'd1: return 14; 2'd2: return 3; default: return 18; endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic model_seed();
        m_s = '1; m_z = 0; max_run = 0; cur_run = 0;
    endtask

    // start the generator: IDLE->ARM->RUN takes two edges
    task automatic do_start();
        @(negedge clk);
        start = 1'b1; bit_en = 1'b1; data_in = 1'b1;
        #1 check("R9", ovr_valid, 1'b0, "ovr_valid in IDLE");
        @(negedge clk);
        #1 check("R9", ovr_valid, 1'b0, "ovr_valid in ARM");
        model_seed();
    endtask

    task automatic do_stop();
        @(negedge clk);
        start = 1'b0; bit_en = 1'b0;
        @(negedge clk);
        bit_en = 1'b1; data_in = 1'b0;
        #1 check("R9", ovr_valid, 1'b0, "ovr_valid after stop");
        check("R9", data_out, 1'b0, "data after stop");
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    // one bit period; prot = the bench's own view of the protection rule
    task automatic drive_bit(input string req, input logic en, input logic fb,
                             input logic t0, input logic t16, input logic prot);
        logic d, raw, expb, adv;
        int   deg, tap, cap;
        @(negedge clk);
        d = 1'($urandom_range(0, 1));
        bit_en = en; data_in = d; frame_bit_mark = fb; ts0_mark = t0; ts16_mark = t16;
        #1;
        deg = deg_of(pat_sel); tap = tap_of(pat_sel);
        cap = (pat_sel >= 2'd2) ? 14 : 7;
        adv = en && !prot;
        raw = m_s[deg-1];
        expb = raw | (zero_lim && !raw && (m_z >= cap));
        check(req, ovr_valid, adv, "ovr_valid");
        check(req, data_out, adv ? expb : d, "data_out");
        if (adv) begin
            m_s = {m_s[21:0], m_s[deg-1] ^ m_s[tap-1]};
            m_z = expb ? 0 : ((m_z < 15) ? m_z + 1 : 15);
            if (data_out === 1'b0) begin
                cur_run++;
                if (cur_run > max_run) max_run = cur_run;
            end else cur_run = 0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        bit_en = 1'b1; data_in = 1'b1;
        #1 check("R11", ovr_valid, 1'b0, "reset ovr_valid");
        check("R11", data_out, 1'b1, "reset pass 1");
        data_in = 1'b0;
        #1 check("R11", data_out, 1'b0, "reset pass 0");
    endtask

    // R1 / R8: unframed, markers pulse freely but must not matter
    task automatic t_pattern(input logic [1:0] sel);
        pat_sel = sel; framed = 1'b0; zero_lim = 1'b0; e1_mode = sel[0];
        do_start();
        for (int i = 0; i < 300; i++) begin
            drive_bit((i % 5 == 0) ? "R8" : "R1", 1'b1, i % 7 == 0, i % 11 == 0, i % 13 == 0, 1'b0);
        end
        do_stop();
    endtask

    // R2 / R3 / R4: limiter
    task automatic t_zlim(input logic [1:0] sel, input int nbits, input string req);
        pat_sel = sel; framed = 1'b0; zero_lim = 1'b1;
        do_start();
        for (int i = 0; i < nbits; i++) drive_bit("R4", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        checks++;
        if (max_run > ((sel >= 2'd2) ? 14 : 7)) begin
            errors++;
            $display("FAIL %s zero run: actual %0d expected <= %0d", req, max_run, (sel >= 2'd2) ? 14 : 7);
        end
        do_stop();
        zero_lim = 1'b0;
    endtask

    // R5 / R7: T1 framed, frame bit every 193
    task automatic t_t1_framed();
        pat_sel = 2'd0; framed = 1'b1; e1_mode = 1'b0; cas_frame = 1'b1;
        do_start();
        for (int i = 0; i < 193 * 4; i++) begin
            drive_bit((i % 193 == 0) ? "R5" : "R7", 1'b1, i % 193 == 0, 1'b0, 1'b0, i % 193 == 0);
        end
        do_stop();
    endtask

    // R6 / R7: E1 framed, 256-bit frame, ts0 = bits 0..7, ts16 = bits 128..135
    task automatic t_e1_framed(input logic cas);
        logic t0, t16;
        pat_sel = 2'd3; framed = 1'b1; e1_mode = 1'b1; cas_frame = cas;
        do_start();
        for (int i = 0; i < 256 * 3; i++) begin
            t0  = (i % 256) < 8;
            t16 = (i % 256) >= 128 && (i % 256) < 136;
            drive_bit("R6", 1'b1, 1'b1, t0, t16, t0 || (cas && t16));
        end
        do_stop();
        framed = 1'b0; e1_mode = 1'b0; cas_frame = 1'b0;
    endtask

    // R10: gaps in bit_en
    task automatic t_gaps();
        pat_sel = 2'd1; framed = 1'b0;
        do_start();
        for (int i = 0; i < 200; i++) drive_bit("R10", (i % 3) != 1, 1'b0, 1'b0, 1'b0, 1'b0);
        do_stop();
    endtask

    // R9: restart reseeds
    task automatic t_restart();
        pat_sel = 2'd2; framed = 1'b0;
        do_start();
        for (int i = 0; i < 60; i++) drive_bit("R9", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        do_stop();
        do_start();
        for (int i = 0; i < 60; i++) drive_bit("R9", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        do_stop();
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        for (int s = 0; s < 4; s++) t_pattern(2'(s));
        t_zlim(2'd0, 3000, "R2");
        t_zlim(2'd1, 1500, "R2");
        t_zlim(2'd3, 3000, "R3");
        t_t1_framed();
        t_e1_framed(1'b1);
        t_e1_framed(1'b0);
        t_gaps();
        t_restart();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule